// File: doc/BRIEF.md
# Store/Recall Protection Controller

This block supervises the whole-array transfers between a shadow RAM and its nonvolatile backup. It owns two latches: a write-enable latch that software must arm, and a previous-recall latch that shows a recall has happened since power-up. It takes store and recall requests from a serial command decoder, as one-cycle command pulses with a 3-bit opcode, and from two active-low hardware pins. A store copies RAM into the backup and is granted only when both latches are set and the supply is good. A recall copies the backup into RAM.

Each granted transfer produces a one-cycle copy strobe toward the storage arrays and holds a busy flag for a cycle count set by a parameter. While busy is high, every other request is dropped. After reset, which models power-up, the block issues one automatic recall strobe and then holds busy for a power-up settling period. The power-up recall does not arm the previous-recall latch: an explicit recall is still needed before any store. A store always wins over a recall requested in the same cycle. A store request that fails its guards is dropped silently, and no error output is given.

The two pins are synchronised and edge-detected, so a pin held low starts at most one operation. Pin requests are ignored while the decoder signals that it is executing an instruction.

Top module: `nvsr_guard_ctrl`

## Requirements
- R1: During reset, wen_latch, rcl_latch and both strobes are 0. On the first clock edge after reset is released, recall_strobe pulses for one cycle while rcl_latch stays 0. busy is high during reset and for PUP_CYC cycles counted from the strobe cycle, then falls.
- R2: Opcode 3'b100 sets wen_latch and opcode 3'b000 clears it. The latch is also cleared on the edge where a store's busy period ends.
- R3: A recall request (opcode 3'b101, or a granted falling edge on recall_n) pulses recall_strobe for one cycle, sets rcl_latch on the same edge, and holds busy for RECALL_CYC cycles counted from the strobe cycle.
- R4: A store request (opcode 3'b001, or a falling edge on store_n) starts a store only if rcl_latch=1, wen_latch=1 and supply_low=0. A granted store pulses store_strobe for one cycle and holds busy for STORE_CYC cycles counted from the strobe cycle. A refused store gives no strobe, no busy and no latch change.
- R5: If a granted store and a recall are requested in the same cycle, only the store runs. While busy is high, every command and pin edge is dropped and leaves no later effect.
- R6: While supply_low is 1, wen_latch reads 0 from the next cycle on, and opcode 3'b100 cannot set it.
- R7: A pin fall is acted on at the third rising clock edge after it, with its strobe visible after that edge. A pin held low starts only one operation. Pin falls that occur while cmd_active is 1 are ignored.
- R8: The unused opcodes 3'b010, 3'b011, 3'b110 and 3'b111 cause no strobe, no busy and no latch change.
- R9: For a command, the strobe, the busy flag and any latch change all appear on the clock edge that samples cmd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_valid | input | 1 | One-cycle pulse from the serial decoder with a decoded opcode |
| cmd_op | input | 3 | Opcode: 000 disable, 001 store, 100 enable, 101 recall |
| cmd_active | input | 1 | Serial decoder is executing an instruction; pin requests are ignored |
| store_n | input | 1 | Asynchronous active-low store request pin |
| recall_n | input | 1 | Asynchronous active-low recall request pin |
| supply_low | input | 1 | Supply below the safe store level |
| store_strobe | output | 1 | One-cycle pulse: copy the whole RAM into the backup |
| recall_strobe | output | 1 | One-cycle pulse: copy the whole backup into RAM |
| busy | output | 1 | Transfer or power-up settling in progress |
| wen_latch | output | 1 | Write-enable latch state |
| rcl_latch | output | 1 | Previous-recall latch state |

## Verification
Store requests are tried with every combination of the two latches and the supply-low input. This separates a guard that tests all three conditions from one that tests only some of them. Requests arrive both as commands and as pin edges, alone, paired in the same cycle, and during busy periods. These patterns expose wrong priority, missing blocking and the extra cycles of pin synchronisation. Held-low pins, pins asserted while the decoder is active, and unused opcodes show whether edge detection and masking are in place. The measured busy lengths check that each of the three timer loads is right.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

  localparam logic [2:0] OPC_WDIS = 3'b000;
  localparam logic [2:0] OPC_STO  = 3'b001;
  localparam logic [2:0] OPC_WEN  = 3'b100;
  localparam logic [2:0] OPC_RCL  = 3'b101;

  typedef enum logic [2:0] {
    ST_PUP,
    ST_HOLD,
    ST_IDLE,
    ST_STORE,
    ST_RECALL
  } nv_state_e;

  function automatic logic store_permitted(input logic rcl, input logic wen, input logic low);
    return rcl & wen & ~low;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvsr_pin_edge.sv
module nvsr_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= pin_n;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else prev_q <= sync_q[STAGES-1];
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  // R7: a held-low pin gives a single edge
  p_single_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/nvsr_dwell_timer.sv
module nvsr_dwell_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4: busy length follows a steady one-per-cycle count
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nvsr_latches.sv
module nvsr_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wen,
  input  logic clr_wen,
  input  logic supply_low,
  input  logic recall_evt,
  output logic wen,
  output logic rcl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wen <= 1'b0;
    else if (supply_low || clr_wen) wen <= 1'b0;
    else if (set_wen) wen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcl <= 1'b0;
    else if (recall_evt) rcl <= 1'b1;
  end

  // R2: the enable latch only rises after an enable request
  p_wen_needs_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> $past(set_wen));

  // R6: a low supply clears the enable latch on the next edge
  p_low_clears_wen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !wen);

endmodule

// File: rtl/nvsr_guard_ctrl.sv
module nvsr_guard_ctrl
  import nvsr_pkg::*;
#(
  parameter int unsigned STORE_CYC   = 64,
  parameter int unsigned RECALL_CYC  = 4,
  parameter int unsigned PUP_CYC     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       cmd_active,
  input  logic       store_n,
  input  logic       recall_n,
  input  logic       supply_low,
  output logic       store_strobe,
  output logic       recall_strobe,
  output logic       busy,
  output logic       wen_latch,
  output logic       rcl_latch
);
  localparam int unsigned LONGEST = max3(STORE_CYC, RECALL_CYC, PUP_CYC);
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  nv_state_e state_q, state_d;
  logic st_fall, rc_fall, expired;
  logic store_req, rcl_req, idle, go_store, go_rcl, store_done;
  logic set_wen, clr_wen, tmr_load;
  logic [CW-1:0] tmr_val;

  nvsr_pin_edge #(.STAGES(SYNC_STAGES)) u_st_edge (
    .clk(clk), .rst_n(rst_n), .pin_n(store_n), .fall(st_fall));
  nvsr_pin_edge #(.STAGES(SYNC_STAGES)) u_rc_edge (
    .clk(clk), .rst_n(rst_n), .pin_n(recall_n), .fall(rc_fall));

  assign idle       = (state_q == ST_IDLE);
  assign store_req  = (cmd_valid && cmd_op == OPC_STO) || (st_fall && !cmd_active);
  assign rcl_req    = (cmd_valid && cmd_op == OPC_RCL) || (rc_fall && !cmd_active);
  assign go_store   = idle && store_req && store_permitted(rcl_latch, wen_latch, supply_low);
  assign go_rcl     = idle && rcl_req && !go_store;
  assign store_done = (state_q == ST_STORE) && expired;
  assign set_wen    = idle && cmd_valid && cmd_op == OPC_WEN && !go_store && !go_rcl;
  assign clr_wen    = store_done || (idle && cmd_valid && cmd_op == OPC_WDIS && !go_store && !go_rcl);

  nvsr_latches u_latches (
    .clk(clk), .rst_n(rst_n), .set_wen(set_wen), .clr_wen(clr_wen),
    .supply_low(supply_low), .recall_evt(go_rcl), .wen(wen_latch), .rcl(rcl_latch));

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = CW'(PUP_CYC - 1);
    if (go_store) tmr_val = CW'(STORE_CYC - 1);
    else if (go_rcl) tmr_val = CW'(RECALL_CYC - 1);
    else if (state_q != ST_PUP) tmr_load = 1'b0;
  end

  nvsr_dwell_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PUP:    state_d = ST_HOLD;
      ST_IDLE:   if (go_store) state_d = ST_STORE;
                 else if (go_rcl) state_d = ST_RECALL;
      default:   if (expired) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_PUP;
      store_strobe  <= 1'b0;
      recall_strobe <= 1'b0;
    end else begin
      state_q       <= state_d;
      store_strobe  <= go_store;
      recall_strobe <= go_rcl || (state_q == ST_PUP);
    end
  end

  assign busy = !idle;

  // R4: a store strobe only follows a cycle with both latches set and a good supply
  p_store_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    store_strobe |-> $past(rcl_latch && wen_latch && !supply_low));

  // R2: the end of a store leaves the enable latch clear
  p_wen_clr_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |=> !wen_latch);

  // R5: never both transfers at once, and nothing starts out of a busy cycle
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_strobe && recall_strobe));
  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_strobe |-> !$past(busy));

  // R3: a granted recall gives a strobe together with the recall latch
  p_rcl_sets_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_rcl |=> (recall_strobe && rcl_latch && busy));

endmodule

// File: tb/tb_nvsr_guard_ctrl.sv
module tb_nvsr_guard_ctrl;
  localparam int STC = 12;
  localparam int RCC = 6;
  localparam int PUC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'b000;
  logic cmd_active = 1'b0;
  logic store_n = 1'b1;
  logic recall_n = 1'b1;
  logic supply_low = 1'b0;
  logic store_strobe, recall_strobe, busy, wen_latch, rcl_latch;

  int total = 0, bad = 0, sc = 0, rc = 0;
  bit m_wen = 0, m_rcl = 0, m_low = 0, done = 0;

  nvsr_guard_ctrl #(.STORE_CYC(STC), .RECALL_CYC(RCC), .PUP_CYC(PUC), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_active(cmd_active), .store_n(store_n), .recall_n(recall_n),
    .supply_low(supply_low), .store_strobe(store_strobe), .recall_strobe(recall_strobe),
    .busy(busy), .wen_latch(wen_latch), .rcl_latch(rcl_latch));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    sc <= sc + int'(store_strobe);
    rc <= rc + int'(recall_strobe);
  end

  function automatic bit model_store_ok(bit r, bit w, bit low);
    return r && w && !low;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_latches(input string req);
    chk(wen_latch == m_wen, {req, " wen"}, int'(wen_latch), int'(m_wen));
    chk(rcl_latch == m_rcl, {req, " rcl"}, int'(rcl_latch), int'(m_rcl));
  endtask

  // R9: a command acts on the edge that samples it
  task automatic do_cmd(input logic [2:0] op);
    bit s_go, r_go;
    int n;
    s_go = (op == 3'b001) && model_store_ok(m_rcl, m_wen, m_low);
    r_go = (op == 3'b101);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3'b100 && !m_low) m_wen = 1;
    if (op == 3'b000) m_wen = 0;
    if (r_go) m_rcl = 1;
    chk(store_strobe == s_go, "R4 R9 store strobe", int'(store_strobe), int'(s_go));
    chk(recall_strobe == r_go, "R3 R9 recall strobe", int'(recall_strobe), int'(r_go));
    chk(busy == (s_go || r_go), "R8 R9 busy", int'(busy), int'(s_go || r_go));
    check_latches("R2 R9");
    if (s_go || r_go) begin
      measure_busy(n);
      chk(n == (s_go ? STC : RCC), "R3 R4 busy length", n, s_go ? STC : RCC);
      if (s_go) m_wen = 0;
      check_latches("R2 after transfer");
    end
  endtask

  task automatic do_pins(input bit ps, input bit pr);
    bit s_go, r_go;
    int n, sc0, rc0;
    s_go = ps && model_store_ok(m_rcl, m_wen, m_low);
    r_go = pr && !s_go;
    @(negedge clk);
    sc0 = sc; rc0 = rc;
    store_n = !ps; recall_n = !pr;
    repeat (2) @(negedge clk);
    chk(!store_strobe && !recall_strobe, "R7 no early strobe",
        int'(store_strobe || recall_strobe), 0);
    @(negedge clk);
    chk(store_strobe == s_go, "R7 R4 pin store", int'(store_strobe), int'(s_go));
    chk(recall_strobe == r_go, "R7 R5 pin recall", int'(recall_strobe), int'(r_go));
    if (r_go) m_rcl = 1;
    check_latches("R7 pin");
    if (s_go || r_go) begin
      measure_busy(n);
      chk(n == (s_go ? STC : RCC), "R7 pin busy length", n, s_go ? STC : RCC);
      if (s_go) m_wen = 0;
    end
    repeat (5) @(negedge clk);
    chk(sc - sc0 == int'(s_go), "R7 held pin single store", sc - sc0, int'(s_go));
    chk(rc - rc0 == int'(r_go), "R7 held pin single recall", rc - rc0, int'(r_go));
    check_latches("R7 pin after");
    store_n = 1'b1; recall_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_low(input bit v);
    @(negedge clk);
    supply_low = v; m_low = v;
    if (v) m_wen = 0;
    @(negedge clk);
    chk(wen_latch == m_wen, "R6 supply low", int'(wen_latch), int'(m_wen));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, sc0, rc0;
    logic [2:0] unused_ops [4];
    void'($urandom(32'd2024));
    unused_ops[0] = 3'b010; unused_ops[1] = 3'b011;
    unused_ops[2] = 3'b110; unused_ops[3] = 3'b111;

    // R1: reset state and power-up recall
    repeat (3) @(negedge clk);
    chk(!wen_latch && !rcl_latch, "R1 latches in reset", int'(wen_latch || rcl_latch), 0);
    chk(!store_strobe && !recall_strobe, "R1 strobes in reset",
        int'(store_strobe || recall_strobe), 0);
    chk(busy, "R1 busy in reset", int'(busy), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(recall_strobe, "R1 power-up recall strobe", int'(recall_strobe), 1);
    chk(!rcl_latch && !wen_latch, "R1 latches after power-up recall",
        int'(rcl_latch || wen_latch), 0);
    measure_busy(n);
    chk(n == PUC, "R1 power-up busy length", n, PUC);
    chk(rc == 1, "R1 single power-up strobe", rc, 1);

    // R4: store refused without the recall latch, even when enabled
    do_cmd(3'b100);
    do_cmd(3'b001);
    // R8: unused opcodes
    for (int i = 0; i < 4; i++) do_cmd(unused_ops[i]);
    // R3: recall arms the latch; R4 store then granted
    do_cmd(3'b101);
    do_cmd(3'b001);
    do_cmd(3'b001);  // R2: refused, store cleared the enable latch
    // R6: enable refused while supply is low, store refused
    do_cmd(3'b100);
    set_low(1'b1);
    do_cmd(3'b100);
    do_cmd(3'b001);
    set_low(1'b0);

    // R5: both pins together, store granted: only the store runs
    do_cmd(3'b100);
    do_pins(1'b1, 1'b1);
    // R5: store refused (latch clear): the recall runs
    do_pins(1'b1, 1'b1);

    // R5: requests during a store busy period are dropped
    do_cmd(3'b100);
    @(negedge clk);
    sc0 = sc; rc0 = rc;
    cmd_valid = 1'b1; cmd_op = 3'b001;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'b101;
    recall_n = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'b100;
    @(negedge clk);
    cmd_valid = 1'b0;
    recall_n = 1'b1;
    while (busy) @(negedge clk);
    m_wen = 0;
    repeat (4) @(negedge clk);
    chk(rc == rc0, "R5 recall dropped during store", rc - rc0, 0);
    chk(sc - sc0 == 1, "R5 single store", sc - sc0, 1);
    chk(!wen_latch, "R5 enable dropped during store", int'(wen_latch), 0);

    // R5: enable during a recall busy period is dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'b101;
    @(negedge clk);
    cmd_op = 3'b100;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(!wen_latch, "R5 enable dropped during recall", int'(wen_latch), 0);

    // R7: pins ignored while the decoder is active
    do_cmd(3'b100);
    @(negedge clk);
    sc0 = sc; rc0 = rc;
    cmd_active = 1'b1; store_n = 1'b0;
    repeat (5) @(negedge clk);
    store_n = 1'b1; recall_n = 1'b0;
    repeat (5) @(negedge clk);
    recall_n = 1'b1;
    repeat (4) @(negedge clk);
    cmd_active = 1'b0;
    repeat (4) @(negedge clk);
    chk(sc == sc0 && rc == rc0, "R7 pins masked by cmd_active", sc - sc0 + rc - rc0, 0);
    chk(!busy && wen_latch, "R7 state after masked pins", int'(busy), 0);
    do_cmd(3'b000);

    // constrained random mix
    for (int it = 0; it < 250; it++) begin
      int k;
      k = int'($urandom_range(0, 9));
      case (k)
        0, 1: do_cmd(3'b100);
        2:    do_cmd(3'b000);
        3, 4: do_cmd(3'b001);
        5:    do_cmd(3'b101);
        6:    do_cmd(unused_ops[$urandom_range(0, 3)]);
        7:    do_pins(1'b1, $urandom_range(0, 3) == 0);
        8:    do_pins(1'b0, 1'b1);
        default: set_low($urandom_range(0, 2) == 0);
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule